// File: doc/BRIEF.md
# End-of-Interrupt Broadcast Forwarder

This block sits in one device of a daisy-chained link, on the path that carries posted writes away from the host. Every packet it accepts from the host side is either relayed to the next device or, when it is an end-of-interrupt broadcast and this device ends the chain, discarded. A packet counts as an end-of-interrupt message when it is a broadcast and its address lies inside the reserved interrupt window. For such a message the block takes the vector from the data dword, compares it with the vector programmed for each local interrupt source, and gives a one-cycle notify pulse to every matching source that asked to be told of service completion.

The block also tracks, for each local source configured to need an end-of-interrupt, whether that source has fired and is still waiting. A waiting source is reported as blocked, so it raises no new level-triggered request until its notify pulse arrives. No reply of any kind is produced for an end-of-interrupt message. Accepted packets leave in arrival order through a single output register, and the host side is stalled while that register holds a packet that the next device has not taken.

Top module: `eoi_relay`

## Requirements
- R1: After reset `dn_valid`, `eoi_notify` and `src_blocked` are all zero and `up_ready` is one.
- R2: A packet with `up_bcast`=1 whose address lies in the window `WIN_LO`..`WIN_HI` (both bounds included; defaults 0xFD_0000_0000 and 0xFD_F8FF_FFFF) is an end-of-interrupt; in the cycle after it is accepted, `eoi_notify[i]` is high for exactly one cycle for every source i whose vector (`src_vector[i*8 +: 8]`) equals `up_data[7:0]` and whose `src_eoi_req[i]` is one.
- R3: A source whose vector differs from the message vector, or whose `src_eoi_req` bit is zero, receives no notify pulse.
- R4: A broadcast whose address is outside the window is forwarded unchanged and produces no notify pulse.
- R5: A packet with `up_bcast`=0 is forwarded unchanged and produces no notify pulse, even with an address in the window.
- R6: With `end_of_chain`=0, an end-of-interrupt is forwarded unchanged to the downstream side, in the cycle after acceptance.
- R7: With `end_of_chain`=1, an end-of-interrupt is dropped (nothing appears downstream) but still notifies; other packets are still forwarded.
- R8: Packets leave in acceptance order; while `dn_valid`=1 and `dn_ready`=0 the output fields stay stable and `up_ready` is zero.
- R9: A `src_fire[i]` pulse on a source with `src_eoi_req[i]`=1 sets `src_blocked[i]` at the next edge; further fires while blocked change nothing; `src_blocked[i]` clears on the same edge its notify pulse starts; a fire with `src_eoi_req[i]`=0 never blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| end_of_chain | input | 1 | This device is the last in the chain |
| up_valid | input | 1 | Host-side packet present |
| up_ready | output | 1 | Host-side packet accepted this cycle when valid |
| up_bcast | input | 1 | Packet is a broadcast |
| up_addr | input | ADDR_W | Packet address |
| up_data | input | DATA_W | Packet data dword |
| dn_valid | output | 1 | Downstream packet present |
| dn_ready | input | 1 | Next device takes the packet |
| dn_bcast | output | 1 | Forwarded broadcast flag |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_data | output | DATA_W | Forwarded data dword |
| src_vector | input | NUM_SRC*VEC_W | Programmed vector of each local source |
| src_eoi_req | input | NUM_SRC | Source wants end-of-interrupt confirmation |
| src_fire | input | NUM_SRC | Source issued an interrupt request this cycle |
| src_blocked | output | NUM_SRC | Source waits for its end-of-interrupt |
| eoi_notify | output | NUM_SRC | One-cycle completion pulse per source |

## Verification
On every cycle the assertions check that a stalled output holds still, that an accepted non-dropped packet appears downstream with the same data, that a dropped message leaves the output empty, that notify pulses only follow an accepted broadcast and only reach sources with the confirmation flag set, and that a waiting source stays blocked until cleared. Which sources a given vector selects, the inclusive window bounds, packet order across a stall, and the ignored fire on an already-blocked source can only be shown by the bench's directed scenarios, which compare forwarded packets and notify counts with values computed from the requirements.

// File: rtl/eoi_relay_pkg.sv
package eoi_relay_pkg;

   typedef enum logic [1:0] {
      PK_PASS     = 2'd0,
      PK_EOI_FWD  = 2'd1,
      PK_EOI_DROP = 2'd2
   } pk_action_t;

   function automatic pk_action_t classify(input logic bcast,
                                           input logic in_win,
                                           input logic last_dev);
      if (!(bcast && in_win))
         return PK_PASS;
      else if (last_dev)
         return PK_EOI_DROP;
      else
         return PK_EOI_FWD;
   endfunction

endpackage

// File: rtl/eoi_window_decode.sv
module eoi_window_decode #(
   parameter int                ADDR_W = 40,
   parameter logic [ADDR_W-1:0] WIN_LO = 40'hFD_0000_0000,
   parameter logic [ADDR_W-1:0] WIN_HI = 40'hFD_F8FF_FFFF
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_win
);
   localparam bit LO_IS_ZERO = (WIN_LO == '0);
   localparam bit HI_IS_TOP  = (WIN_HI == '1);

   generate
      if (WIN_LO > WIN_HI) begin : g_bad_window
         $error("eoi_window_decode: WIN_LO above WIN_HI");
      end
      if (LO_IS_ZERO && HI_IS_TOP) begin : g_all
         assign in_win = 1'b1;
      end else if (LO_IS_ZERO) begin : g_hi_only
         assign in_win = (addr <= WIN_HI);
      end else if (HI_IS_TOP) begin : g_lo_only
         assign in_win = (addr >= WIN_LO);
      end else begin : g_both
         assign in_win = (addr >= WIN_LO) && (addr <= WIN_HI);
      end
   endgenerate

endmodule

// File: rtl/eoi_vector_match.sv
module eoi_vector_match #(
   parameter int VEC_W   = 8,
   parameter int NUM_SRC = 4
) (
   input  logic [VEC_W-1:0]         msg_vec,
   input  logic [NUM_SRC*VEC_W-1:0] src_vector,
   input  logic [NUM_SRC-1:0]       src_eoi_req,
   output logic [NUM_SRC-1:0]       hit
);
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         assign hit[i] = src_eoi_req[i] && (src_vector[i*VEC_W +: VEC_W] == msg_vec);
      end
   endgenerate

endmodule

// File: rtl/eoi_wait_tracker.sv
module eoi_wait_tracker #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] fire,
   input  logic [NUM_SRC-1:0] needs_eoi,
   input  logic [NUM_SRC-1:0] release_mask,
   output logic [NUM_SRC-1:0] waiting
);
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_trk
         logic wait_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               wait_q <= 1'b0;
            else if (wait_q)
               wait_q <= !release_mask[i];
            else
               wait_q <= fire[i] && needs_eoi[i];
         end
         assign waiting[i] = wait_q;

         AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_q && !release_mask[i]) |=> wait_q); // R9
         AST_NO_BLOCK_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (!wait_q && !(fire[i] && needs_eoi[i])) |=> !wait_q); // R9
      end
   endgenerate

endmodule

// File: rtl/eoi_relay.sv
module eoi_relay
   import eoi_relay_pkg::*;
#(
   parameter int                ADDR_W  = 40,
   parameter int                DATA_W  = 32,
   parameter int                VEC_W   = 8,
   parameter int                VEC_LSB = 0,
   parameter int                NUM_SRC = 4,
   parameter logic [ADDR_W-1:0] WIN_LO  = 40'hFD_0000_0000,
   parameter logic [ADDR_W-1:0] WIN_HI  = 40'hFD_F8FF_FFFF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     end_of_chain,
   input  logic                     up_valid,
   output logic                     up_ready,
   input  logic                     up_bcast,
   input  logic [ADDR_W-1:0]        up_addr,
   input  logic [DATA_W-1:0]        up_data,
   output logic                     dn_valid,
   input  logic                     dn_ready,
   output logic                     dn_bcast,
   output logic [ADDR_W-1:0]        dn_addr,
   output logic [DATA_W-1:0]        dn_data,
   input  logic [NUM_SRC*VEC_W-1:0] src_vector,
   input  logic [NUM_SRC-1:0]       src_eoi_req,
   input  logic [NUM_SRC-1:0]       src_fire,
   output logic [NUM_SRC-1:0]       src_blocked,
   output logic [NUM_SRC-1:0]       eoi_notify
);
   localparam int VEC_MSB = VEC_LSB + VEC_W - 1;

   generate
      if (VEC_MSB >= DATA_W) begin : g_bad_vec
         $error("eoi_relay: vector field exceeds data width");
      end
      if (NUM_SRC < 1) begin : g_bad_src
         $error("eoi_relay: NUM_SRC must be at least 1");
      end
   endgenerate

   logic               in_win;
   logic [NUM_SRC-1:0] hit;
   logic [NUM_SRC-1:0] release_mask;
   logic               accept;
   pk_action_t         action;

   logic               out_v_q;
   logic               out_b_q;
   logic [ADDR_W-1:0]  out_a_q;
   logic [DATA_W-1:0]  out_d_q;
   logic [NUM_SRC-1:0] notify_q;

   eoi_window_decode #(
      .ADDR_W (ADDR_W),
      .WIN_LO (WIN_LO),
      .WIN_HI (WIN_HI)
   ) u_win (
      .addr   (up_addr),
      .in_win (in_win)
   );

   eoi_vector_match #(
      .VEC_W   (VEC_W),
      .NUM_SRC (NUM_SRC)
   ) u_match (
      .msg_vec     (up_data[VEC_MSB:VEC_LSB]),
      .src_vector  (src_vector),
      .src_eoi_req (src_eoi_req),
      .hit         (hit)
   );

   assign up_ready     = !out_v_q || dn_ready;
   assign accept       = up_valid && up_ready;
   assign action       = classify(up_bcast, in_win, end_of_chain);
   assign release_mask = (accept && (action != PK_PASS)) ? hit : '0;

   eoi_wait_tracker #(
      .NUM_SRC (NUM_SRC)
   ) u_trk (
      .clk          (clk),
      .rst_n        (rst_n),
      .fire         (src_fire),
      .needs_eoi    (src_eoi_req),
      .release_mask (release_mask),
      .waiting      (src_blocked)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v_q  <= 1'b0;
         out_b_q  <= 1'b0;
         out_a_q  <= '0;
         out_d_q  <= '0;
         notify_q <= '0;
      end else begin
         notify_q <= release_mask;
         if (out_v_q && dn_ready)
            out_v_q <= 1'b0;
         if (accept && (action != PK_EOI_DROP)) begin
            out_v_q <= 1'b1;
            out_b_q <= up_bcast;
            out_a_q <= up_addr;
            out_d_q <= up_data;
         end
      end
   end

   assign dn_valid   = out_v_q;
   assign dn_bcast   = out_b_q;
   assign dn_addr    = out_a_q;
   assign dn_data    = out_d_q;
   assign eoi_notify = notify_q;

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data) && $stable(dn_addr) && $stable(dn_bcast))); // R8
   AST_FORWARD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready && !(up_bcast && in_win && end_of_chain))
         |=> (dn_valid && dn_data == $past(up_data) && dn_addr == $past(up_addr))); // R6
   AST_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready && up_bcast && in_win && end_of_chain) |=> !dn_valid); // R7
   AST_NOTIFY_FROM_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_notify != '0) |-> $past(up_valid && up_ready && up_bcast)); // R5
   AST_NOTIFY_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_notify != '0) |-> ((eoi_notify & ~$past(src_eoi_req)) == '0)); // R3

endmodule

// File: tb/eoi_relay_tb_top.sv
module eoi_relay_tb_top;
   localparam int AW = 40;
   localparam int DW = 32;
   localparam int NS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          end_of_chain = 1'b0;
   logic          up_valid = 1'b0;
   logic          up_ready;
   logic          up_bcast = 1'b0;
   logic [AW-1:0] up_addr = '0;
   logic [DW-1:0] up_data = '0;
   logic          dn_valid;
   logic          dn_ready = 1'b1;
   logic          dn_bcast;
   logic [AW-1:0] dn_addr;
   logic [DW-1:0] dn_data;
   logic [NS*8-1:0] src_vector;
   logic [NS-1:0] src_eoi_req;
   logic [NS-1:0] src_fire = '0;
   logic [NS-1:0] src_blocked;
   logic [NS-1:0] eoi_notify;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   // source 0: vec 0x21 flag 1; 1: 0x21 flag 0; 2: 0x35 flag 1; 3: 0x21 flag 1
   assign src_vector  = {8'h21, 8'h35, 8'h21, 8'h21};
   assign src_eoi_req = 4'b1101;

   eoi_relay dut_i (
      .clk(clk), .rst_n(rst_n), .end_of_chain(end_of_chain),
      .up_valid(up_valid), .up_ready(up_ready), .up_bcast(up_bcast),
      .up_addr(up_addr), .up_data(up_data),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_bcast(dn_bcast),
      .dn_addr(dn_addr), .dn_data(dn_data),
      .src_vector(src_vector), .src_eoi_req(src_eoi_req),
      .src_fire(src_fire), .src_blocked(src_blocked), .eoi_notify(eoi_notify)
   );

   logic [AW+DW:0] rx_q[$];
   int note_cnt[NS];

   initial for (int i = 0; i < NS; i++) note_cnt[i] = 0;

   always @(posedge clk) begin
      if (rst_n && dn_valid && dn_ready) rx_q.push_back({dn_bcast, dn_addr, dn_data});
      for (int i = 0; i < NS; i++) if (rst_n && eoi_notify[i]) note_cnt[i]++;
   end

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic b, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      up_valid = 1'b1; up_bcast = b; up_addr = a; up_data = d;
      #1;
      while (!up_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic fire(input logic [NS-1:0] m);
      @(negedge clk);
      src_fire = m;
      @(negedge clk);
      src_fire = '0;
   endtask

   task automatic snap(output int s[NS]);
      for (int i = 0; i < NS; i++) s[i] = note_cnt[i];
   endtask

   task automatic chk_notes(input string tag, input int s[NS], input int e0, input int e1,
                            input int e2, input int e3);
      chk({tag, " src0"}, note_cnt[0] - s[0], e0);
      chk({tag, " src1"}, note_cnt[1] - s[1], e1);
      chk({tag, " src2"}, note_cnt[2] - s[2], e2);
      chk({tag, " src3"}, note_cnt[3] - s[3], e3);
   endtask

   task automatic chk_rx(input string tag, input logic b, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
      if (rx_q.size() == 0) chk({tag, " rx count"}, 0, 1);
      else chk(tag, rx_q.pop_front(), {b, a, d});
   endtask

   task automatic t_reset;
      wait_cyc(1);
      chk("R1 dn_valid", dn_valid, 0);
      chk("R1 eoi_notify", eoi_notify, 0);
      chk("R1 src_blocked", src_blocked, 0);
      chk("R1 up_ready", up_ready, 1);
   endtask

   task automatic t_eoi_forward;
      int s[NS];
      end_of_chain = 1'b0;
      fire(4'b1111);
      wait_cyc(1);
      chk("R9 blocked after fire", src_blocked, 4'b1101);
      snap(s);
      send(1'b1, 40'hFD_0000_1000, 32'hABCD_0021);
      wait_cyc(2);
      chk_notes("R2/R3 vec 21", s, 1, 0, 0, 1);
      chk("R9 released", src_blocked, 4'b0100);
      chk_rx("R6 eoi forwarded", 1'b1, 40'hFD_0000_1000, 32'hABCD_0021);
   endtask

   task automatic t_blocking_and_bounds;
      int s[NS];
      fire(4'b0110);
      wait_cyc(1);
      chk("R9 refire ignored, flagless no block", src_blocked, 4'b0100);
      snap(s);
      send(1'b1, 40'hFD_F8FF_FFFF, 32'h0000_0035);
      wait_cyc(2);
      chk_notes("R2 upper bound vec 35", s, 0, 0, 1, 0);
      chk("R9 src2 released", src_blocked, 4'b0000);
      chk_rx("R6 upper bound fwd", 1'b1, 40'hFD_F8FF_FFFF, 32'h0000_0035);
      snap(s);
      send(1'b1, 40'hFD_0000_0000, 32'h1234_5621);
      wait_cyc(2);
      chk_notes("R2 lower bound", s, 1, 0, 0, 1);
      chk_rx("R6 lower bound fwd", 1'b1, 40'hFD_0000_0000, 32'h1234_5621);
      snap(s);
      send(1'b1, 40'hFD_0000_0040, 32'h0000_0099);
      wait_cyc(2);
      chk_notes("R3 no vector match", s, 0, 0, 0, 0);
      chk_rx("R6 unmatched fwd", 1'b1, 40'hFD_0000_0040, 32'h0000_0099);
   endtask

   task automatic t_outside;
      int s[NS];
      snap(s);
      send(1'b1, 40'hFD_F900_0000, 32'h0000_0021);
      send(1'b1, 40'hFC_FFFF_FFFF, 32'h0000_0021);
      wait_cyc(2);
      chk_notes("R4 outside window", s, 0, 0, 0, 0);
      chk_rx("R4 above fwd", 1'b1, 40'hFD_F900_0000, 32'h0000_0021);
      chk_rx("R4 below fwd", 1'b1, 40'hFC_FFFF_FFFF, 32'h0000_0021);
   endtask

   task automatic t_nonbcast;
      int s[NS];
      snap(s);
      send(1'b0, 40'hFD_0000_2000, 32'h0000_0021);
      wait_cyc(2);
      chk_notes("R5 non-broadcast", s, 0, 0, 0, 0);
      chk_rx("R5 non-broadcast fwd", 1'b0, 40'hFD_0000_2000, 32'h0000_0021);
   endtask

   task automatic t_drop;
      int s[NS];
      end_of_chain = 1'b1;
      snap(s);
      send(1'b1, 40'hFD_1000_0000, 32'h0000_0021);
      wait_cyc(3);
      chk_notes("R7 drop still notifies", s, 1, 0, 0, 1);
      chk("R7 nothing downstream", rx_q.size(), 0);
      send(1'b1, 40'h12_0000_0000, 32'h0000_0021);
      wait_cyc(2);
      chk_rx("R7 other broadcast fwd", 1'b1, 40'h12_0000_0000, 32'h0000_0021);
      end_of_chain = 1'b0;
   endtask

   task automatic t_backpressure;
      @(negedge clk);
      dn_ready = 1'b0;
      send(1'b0, 40'h00_0000_0100, 32'h1111_1111);
      fork
         send(1'b0, 40'h00_0000_0200, 32'h2222_2222);
         begin
            wait_cyc(4);
            chk("R8 up_ready low in stall", up_ready, 0);
            chk("R8 held data", dn_data, 32'h1111_1111);
            chk("R8 held valid", dn_valid, 1);
            dn_ready = 1'b1;
         end
      join
      send(1'b0, 40'h00_0000_0300, 32'h3333_3333);
      wait_cyc(3);
      chk_rx("R8 order 1", 1'b0, 40'h00_0000_0100, 32'h1111_1111);
      chk_rx("R8 order 2", 1'b0, 40'h00_0000_0200, 32'h2222_2222);
      chk_rx("R8 order 3", 1'b0, 40'h00_0000_0300, 32'h3333_3333);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_eoi_forward();
      t_blocking_and_bounds();
      t_outside();
      t_nonbcast();
      t_drop();
      t_backpressure();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule